// File: doc/BRIEF.md
# Row-Driver Pattern Initializer

This sequencer prepares the part of a 165-column by 65-line display memory that feeds the row-driver outputs. When a panel is wired so that some column outputs act as row drivers, every memory line needs a single 1 in the column that drives the matching panel line, and 0 in every other column of that row-driver region. The block computes this one-hot diagonal itself and writes it one bit per cycle.

The host gives the region code, the number of panel lines in use, the column that drives the first line, and whether later lines sit on higher or lower columns. A start pulse begins the run. The block drops the protect control, sweeps every line of the region, raises protect again and then pulses done. Arbitration of the memory port against other masters, and the display scan, are handled outside this block.

Top module: `rowfill_init`

## Requirements
- R1: For memory line j (0 to lines-1), exactly one write carries a 1. It goes to the mapped column of R5 when that column lies inside the region. Every other region column on that line is written with 0. When the mapped column falls outside the region, the whole line is written with 0s.
- R2: The region is chosen by `mode_i`. Code 0 means no region. Code 1 is columns 100..164. Code 2 is columns 0..31 together with columns 132..164. Code 3 is columns 132..164.
- R3: With region code 0, or with `nlines_i` = 0, no write occurs. `done_o` is high in the cycle after start is accepted, and `prot_o` stays high throughout.
- R4: `prot_o` goes low in the cycle after start is accepted, which is one full cycle before the first write. It stays low for every write. It returns high in the cycle after the last write.
- R5: The mapped column for line j is col0 − j when `dir_i` = 0, and col0 + j when `dir_i` = 1. Both use values captured at start.
- R6: Writes are issued one per consecutive cycle. Lines go in ascending order. Within a line, columns go in ascending order, so in code 2 the columns 0..31 come before 132..164.
- R7: `done_o` is a one-cycle pulse in the cycle after `prot_o` returns high. `busy_o` is high from the cycle after start up to and including the done cycle.
- R8: `start_i`, and any change to the configuration inputs while `busy_o` is high, have no effect on the write sequence.
- R9: After reset, `prot_o` is high and `busy_o`, `done_o` and `wr_en_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Begin a run when idle |
| mode_i | input | 2 | Region code (R2) |
| dir_i | input | 1 | 0: mapped column falls per line, 1: rises per line |
| col0_i | input | 8 | Column wired to the first panel line |
| nlines_i | input | 7 | Number of lines to fill (0..65) |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| prot_o | output | 1 | Protect control for the row-driver region, high means protected |
| wr_en_o | output | 1 | Memory bit write strobe |
| wr_col_o | output | 8 | Column of the bit being written |
| wr_row_o | output | 7 | Memory line of the bit being written |
| wr_bit_o | output | 1 | Bit value written |

## Verification
The hardest situations to reach are a mapped column that lands in the gap between the two sweeps of code 2, or that leaves the memory entirely, because in those cases a line gets no 1 at all. The stimulus reaches them by choosing a first column and direction whose diagonal runs from one region through the gap (for example 164 falling, or 0 rising, in code 2) and off the low end (31 falling). Every written bit of each full 65-line sweep is compared against arithmetic predictions. One run also holds start high with altered configuration for its whole length, to show that the captured setup is kept.

// File: rtl/rowfill_pkg.sv
package rowfill_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_UNPROT = 3'd1,
    ST_WRITE = 3'd2,
    ST_REPROT = 3'd3,
    ST_FINISH = 3'd4
  } rowfill_state_e;

  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_RIGHT_WIDE = 2'd1,
    RG_SPLIT = 2'd2,
    RG_RIGHT_NARROW = 2'd3
  } rowfill_region_e;
endpackage

// File: rtl/rowfill_rst_sync.sv
module rowfill_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rowfill_area.sv
module rowfill_area
  import rowfill_pkg::*;
#(
  parameter int NCOLS = 165,
  parameter int WIDE_LO = 100,
  parameter int NARROW_LO = 132,
  parameter int LEFT_HI = 31,
  localparam int CW = $clog2(NCOLS)
) (
  input  rowfill_region_e region,
  input  logic [CW-1:0]   col,
  output logic [CW-1:0]   first_col,
  output logic [CW-1:0]   next_col,
  output logic            line_end,
  output logic            in_area
);
  localparam logic [CW-1:0] COL_LAST = CW'(NCOLS - 1);
  localparam logic [CW-1:0] WIDE_FIRST = CW'(WIDE_LO);
  localparam logic [CW-1:0] NARROW_FIRST = CW'(NARROW_LO);
  localparam logic [CW-1:0] LEFT_LAST = CW'(LEFT_HI);

  always_comb begin
    unique case (region)
      RG_RIGHT_WIDE:   first_col = WIDE_FIRST;
      RG_RIGHT_NARROW: first_col = NARROW_FIRST;
      default:         first_col = '0;
    endcase
  end

  always_comb begin
    if (region == RG_SPLIT && col == LEFT_LAST) next_col = NARROW_FIRST;
    else                                        next_col = col + 1'b1;
  end

  assign line_end = (col == COL_LAST);

  always_comb begin
    unique case (region)
      RG_RIGHT_WIDE:   in_area = (col >= WIDE_FIRST) && (col <= COL_LAST);
      RG_SPLIT:        in_area = (col <= LEFT_LAST) ||
                                 ((col >= NARROW_FIRST) && (col <= COL_LAST));
      RG_RIGHT_NARROW: in_area = (col >= NARROW_FIRST) && (col <= COL_LAST);
      default:         in_area = 1'b0;
    endcase
  end
endmodule

// File: rtl/rowfill_map.sv
module rowfill_map #(
  parameter int NCOLS = 165,
  parameter int NLINES = 65,
  localparam int CW = $clog2(NCOLS),
  localparam int RW = $clog2(NLINES),
  localparam int TW = CW + 2
) (
  input  logic [CW-1:0] col0,
  input  logic          dir_up,
  input  logic [RW-1:0] line,
  input  logic [CW-1:0] col,
  output logic          hit
);
  logic [TW-1:0] base_w, step_w, target_w, col_w;

  assign base_w = {{(TW-CW){1'b0}}, col0};
  assign step_w = {{(TW-RW){1'b0}}, line};
  assign col_w  = {{(TW-CW){1'b0}}, col};

  // A falling diagonal that runs below column 0 wraps into the top half of
  // the widened value and so never matches a real column.
  assign target_w = dir_up ? (base_w + step_w) : (base_w - step_w);
  assign hit      = (target_w == col_w);
endmodule

// File: rtl/rowfill_init.sv
module rowfill_init
  import rowfill_pkg::*;
#(
  parameter int NCOLS = 165,
  parameter int NLINES = 65,
  parameter int WIDE_LO = 100,
  parameter int NARROW_LO = 132,
  parameter int LEFT_HI = 31,
  parameter int SYNC_STAGES = 2,
  localparam int CW = $clog2(NCOLS),
  localparam int RW = $clog2(NLINES),
  localparam int LW = $clog2(NLINES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    mode_i,
  input  logic          dir_i,
  input  logic [CW-1:0] col0_i,
  input  logic [LW-1:0] nlines_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          prot_o,
  output logic          wr_en_o,
  output logic [CW-1:0] wr_col_o,
  output logic [RW-1:0] wr_row_o,
  output logic          wr_bit_o
);
  logic rst_s_n;

  rowfill_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n)
  );

  rowfill_state_e  st_q, st_d;
  rowfill_region_e region_q;
  logic            dir_q;
  logic [CW-1:0]   col0_q;
  logic [LW-1:0]   nl_q;
  logic [RW-1:0]   line_q, line_d;
  logic [CW-1:0]   col_q, col_d;
  logic            prot_q, prot_d;
  logic            cfg_en, walk_en, prot_en;

  logic [CW-1:0] first_col, next_col;
  logic          line_end, in_area, hit;

  rowfill_area #(
    .NCOLS(NCOLS), .WIDE_LO(WIDE_LO), .NARROW_LO(NARROW_LO), .LEFT_HI(LEFT_HI)
  ) u_area (
    .region(region_q), .col(col_q), .first_col(first_col),
    .next_col(next_col), .line_end(line_end), .in_area(in_area)
  );

  rowfill_map #(.NCOLS(NCOLS), .NLINES(NLINES)) u_map (
    .col0(col0_q), .dir_up(dir_q), .line(line_q), .col(col_q), .hit(hit)
  );

  logic last_line;
  assign last_line = ({{(LW-RW){1'b0}}, line_q} == (nl_q - 1'b1));
  assign cfg_en    = (st_q == ST_IDLE) && start_i;

  // next-state process
  always_comb begin
    st_d    = st_q;
    line_d  = line_q;
    col_d   = col_q;
    prot_d  = prot_q;
    walk_en = 1'b0;
    prot_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          if (mode_i == 2'd0 || nlines_i == '0) begin
            st_d = ST_FINISH;
          end else begin
            st_d    = ST_UNPROT;
            prot_d  = 1'b0;
            prot_en = 1'b1;
          end
        end
      end
      ST_UNPROT: begin
        st_d    = ST_WRITE;
        line_d  = '0;
        col_d   = first_col;
        walk_en = 1'b1;
      end
      ST_WRITE: begin
        walk_en = 1'b1;
        if (line_end) begin
          if (last_line) begin
            st_d    = ST_REPROT;
            prot_d  = 1'b1;
            prot_en = 1'b1;
          end else begin
            line_d = line_q + 1'b1;
            col_d  = first_col;
          end
        end else begin
          col_d = next_col;
        end
      end
      ST_REPROT: st_d = ST_FINISH;
      ST_FINISH: st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  // register processes
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) st_q <= ST_IDLE;
    else          st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)     prot_q <= 1'b1;
    else if (prot_en) prot_q <= prot_d;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      line_q <= '0;
      col_q  <= '0;
    end else if (walk_en) begin
      line_q <= line_d;
      col_q  <= col_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      region_q <= RG_NONE;
      dir_q    <= 1'b0;
      col0_q   <= '0;
      nl_q     <= '0;
    end else if (cfg_en) begin
      region_q <= rowfill_region_e'(mode_i);
      dir_q    <= dir_i;
      col0_q   <= col0_i;
      nl_q     <= nlines_i;
    end
  end

  assign busy_o   = (st_q != ST_IDLE);
  assign done_o   = (st_q == ST_FINISH);
  assign prot_o   = prot_q;
  assign wr_en_o  = (st_q == ST_WRITE);
  assign wr_col_o = col_q;
  assign wr_row_o = line_q;
  assign wr_bit_o = hit;

  AST_WR_UNPROTECTED: assert property (@(posedge clk) disable iff (!rst_s_n)
    wr_en_o |-> !prot_o);  // R4
  AST_UNPROT_AHEAD: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(wr_en_o) |-> $past(!prot_o));  // R4
  AST_DONE_PROTECTED: assert property (@(posedge clk) disable iff (!rst_s_n)
    done_o |-> prot_o);  // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    done_o |=> !done_o);  // R7
  AST_COL_IN_AREA: assert property (@(posedge clk) disable iff (!rst_s_n)
    wr_en_o |-> in_area);  // R2
  AST_ROW_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_s_n)
    wr_en_o |-> ({{(LW-RW){1'b0}}, wr_row_o} < nl_q));  // R1
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_s_n)
    busy_o |=> ($stable(region_q) && $stable(col0_q) && $stable(dir_q) && $stable(nl_q)));  // R8
  AST_IDLE_PROTECTED: assert property (@(posedge clk) disable iff (!rst_s_n)
    !busy_o |-> prot_o);  // R9
endmodule

// File: tb/rowfill_init_tb_top.sv
module rowfill_init_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [1:0] mode_i;
  logic       dir_i;
  logic [7:0] col0_i;
  logic [6:0] nlines_i;
  logic       busy_o, done_o, prot_o, wr_en_o, wr_bit_o;
  logic [7:0] wr_col_o;
  logic [6:0] wr_row_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rowfill_init dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .dir_i(dir_i), .col0_i(col0_i), .nlines_i(nlines_i),
    .busy_o(busy_o), .done_o(done_o), .prot_o(prot_o), .wr_en_o(wr_en_o),
    .wr_col_o(wr_col_o), .wr_row_o(wr_row_o), .wr_bit_o(wr_bit_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit area_has(input int m, input int c);
    case (m)
      1: return c >= 100;
      2: return (c <= 31) || (c >= 132);
      3: return c >= 132;
      default: return 1'b0;
    endcase
  endfunction

  task automatic run(input int m, input int d, input int c0, input int nl, input bit hold);
    int target;
    @(negedge clk);
    start_i = 1'b1; mode_i = 2'(m); dir_i = d[0]; col0_i = 8'(c0); nlines_i = 7'(nl);
    @(negedge clk);
    if (hold) begin
      mode_i = 2'd0; col0_i = 8'd7; nlines_i = 7'd3; dir_i = ~dir_i;
    end else begin
      start_i = 1'b0;
    end
    if (m == 0 || nl == 0) begin
      chk(done_o && prot_o && !wr_en_o, "R3 immediate done, protect kept",
          {done_o, prot_o, wr_en_o}, 3'b110);
      start_i = 1'b0;
      @(negedge clk);
      chk(!done_o && !busy_o && !wr_en_o, "R3 back to idle", {done_o, busy_o}, 0);
      return;
    end
    chk(busy_o && !prot_o && !wr_en_o, "R4 protect off before writes",
        {busy_o, prot_o, wr_en_o}, 3'b100);
    for (int l = 0; l < nl; l++) begin
      target = (d != 0) ? c0 + l : c0 - l;
      for (int c = 0; c < 165; c++) begin
        if (area_has(m, c)) begin
          @(negedge clk);
          // R1 R5 R6: one write per cycle, ascending order, one-hot at target
          chk(wr_en_o && !prot_o && wr_col_o == 8'(c) && wr_row_o == 7'(l) &&
              wr_bit_o == (c == target),
              "R1 R5 R6 write stream",
              {wr_en_o, prot_o, wr_row_o, wr_col_o, wr_bit_o},
              {1'b1, 1'b0, 7'(l), 8'(c), 1'(c == target)});
        end
      end
    end
    @(negedge clk);
    chk(prot_o && !wr_en_o && !done_o && busy_o, "R4 protect back on after last write",
        {prot_o, wr_en_o, done_o, busy_o}, 4'b1001);
    @(negedge clk);
    chk(done_o && busy_o && prot_o, "R7 done pulse after protect",
        {done_o, busy_o, prot_o}, 3'b111);
    start_i = 1'b0;
    @(negedge clk);
    chk(!done_o && !busy_o && !wr_en_o, "R7 R8 done single cycle, idle", {done_o, busy_o}, 0);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; mode_i = '0; dir_i = 1'b0; col0_i = '0; nlines_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(prot_o && !busy_o && !done_o && !wr_en_o, "R9 reset state",
        {prot_o, busy_o, done_o, wr_en_o}, 4'b1000);

    run(1, 0, 164, 65, 1'b0);   // R2 R5 wide region, falling diagonal
    run(1, 1, 100, 65, 1'b0);   // R5 rising diagonal
    run(2, 0, 164, 65, 1'b0);   // R1 diagonal through the split gap
    run(2, 1, 0, 65, 1'b0);     // R6 left range first, rising
    run(2, 0, 31, 40, 1'b0);    // R1 target below column 0
    run(3, 0, 164, 33, 1'b0);   // R2 narrow region
    run(3, 1, 132, 33, 1'b0);
    run(3, 0, 150, 20, 1'b0);   // partial line count
    run(1, 1, 160, 1, 1'b0);    // single line
    run(0, 0, 164, 65, 1'b0);   // R3 no region
    run(1, 0, 164, 0, 1'b0);    // R3 zero lines
    run(3, 1, 140, 33, 1'b1);   // R8 start held, config altered while busy
    run(2, 1, 10, 65, 1'b0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule